// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block models a single-port synchronous static RAM whose write data trails its address by a fixed number of clock edges. Because of that late-write scheme, a write command may follow a read command in the very next cycle, and the reverse, with no idle cycle on the data bus. The array has 512 words of 18 bits, split into two 9-bit byte lanes, and every size is a parameter.

Commands are sampled on the rising edge. A load cycle starts an access at a new address. An advance cycle continues the current access through a two-bit burst, in linear or interleaved order. A static mode strap selects between two timings. In registered-output timing, read data appears one cycle after the command cycle and write data is taken two edges after its address. In flow-through timing, read data appears in the command cycle itself and write data is taken one edge after its address.

Output enable and sleep act on the output at once, without waiting for a clock edge. The data bus is modelled as a split input/output pair plus a drive flag.

Top module: `zt_sram`

## Requirements
- R1: While `rst` is high and after its release, `dout_en` is 0 and `dout` is 0. An advance cycle that follows reset starts no access.
- R2: In registered-output timing (`flow_mode`=0), a read command sampled at edge n drives `dout_en`=1 with the word between edges n+1 and n+2.
- R3: In flow-through timing (`flow_mode`=1), a read command sampled at edge n drives `dout_en`=1 with the word between edges n and n+1.
- R4: Write data on `din` is taken at edge n+2 in registered-output timing and at edge n+1 in flow-through timing, where n is the edge at which the write command was sampled.
- R5: Read and write commands may alternate on consecutive cycles with no deselect cycle between them, and every read still returns the correct word.
- R6: Byte lane i covers bits [9i+8:9i]. A write changes lane i only when `lane_we[i]` is 1 in the command cycle.
- R7: A load cycle is selected only when `ce_a`, `ce_b` and `ce_c` are all 1. Any other combination is a deselect cycle: nothing is written and no read data is driven.
- R8: `dout_en` is 0 while `oe` is 0, with no clock edge needed. `dout` is 0 whenever `dout_en` is 0.
- R9: While `sleep` is 1, `dout_en` is 0 at once. Commands sampled during sleep are ignored, no array write takes place, and the stored contents are kept.
- R10: An advance cycle (`adv_ld`=1) continues the current access with the same read or write direction. During it, `we`, `addr` and the chip enables are ignored. The low two address bits step from the loaded value: base+k mod 4 when `lin_burst`=1, or base XOR k when `lin_burst`=0, for k = 1, 2, 3, then wrapping.
- R11: In registered-output timing, a read whose address matches a write being committed at the same edge returns that write's new data in the enabled lanes and the stored data in the other lanes.
- R12: An advance cycle with no access in progress (after a deselect, sleep or reset) is a deselect cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flow_mode | input | 1 | Static strap: 1 = flow-through timing, 0 = registered-output timing |
| lin_burst | input | 1 | Static strap: 1 = linear burst order, 0 = interleaved |
| addr | input | ADDR_W (9) | Word address, sampled on load cycles |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load a new command |
| we | input | 1 | 1 = write, 0 = read, sampled on load cycles |
| lane_we | input | LANES (2) | Per-lane write enables, sampled every command cycle |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| ce_c | input | 1 | Chip enable, active high |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep, active high |
| din | input | DATA_W (18) | Late write data |
| dout | output | DATA_W (18) | Read data, zero when not driven |
| dout_en | output | 1 | Bus drive flag |

## Verification
The assertions assume that `flow_mode` and `lin_burst` change only while `rst` is high. Under that assumption, the timing relations between the command stage and `dout_en` stay well defined. The stimulus changes both straps only inside its reset task, and holds `sleep` and `oe` changes away from the active clock edge. The bench reads only locations it has written first, so every expected word, including the merged words of masked and forwarded writes, is defined.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  localparam int BURST_W = 2;

  // next low address bits of a burst, step k from the loaded base
  function automatic logic [BURST_W-1:0] burst_lo(input logic lin,
                                                  input logic [BURST_W-1:0] base,
                                                  input logic [BURST_W-1:0] k);
    return lin ? base + k : base ^ k;
  endfunction
endpackage

// File: rtl/zt_sram_seq.sv
module zt_sram_seq #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              lin_burst,
  input  logic              adv_ld,
  input  logic              we,
  input  logic              sel_all,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we,
  output logic              c_v,
  output logic              c_wr,
  output logic [ADDR_W-1:0] c_addr,
  output logic [LANES-1:0]  c_lanes
);
  import zt_sram_pkg::*;
  localparam int BW = BURST_W;
  localparam logic [BW-1:0] ONE = 1;

  logic [ADDR_W-1:0] base_q;
  logic [BW-1:0]     step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_v     <= 1'b0;
      c_wr    <= 1'b0;
      c_addr  <= '0;
      c_lanes <= '0;
      base_q  <= '0;
      step_q  <= '0;
    end else begin
      c_lanes <= lane_we;
      if (sleep) begin
        c_v <= 1'b0;
      end else if (!adv_ld) begin
        c_v    <= sel_all;
        c_wr   <= we;
        c_addr <= addr;
        base_q <= addr;
        step_q <= '0;
      end else if (c_v) begin
        step_q <= step_q + ONE;
        c_addr <= {base_q[ADDR_W-1:BW],
                   burst_lo(lin_burst, base_q[BW-1:0], step_q + ONE)};
      end
    end
  end
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[g])
        mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flow_mode,
  input  logic              lin_burst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_ld,
  input  logic              we,
  input  logic [LANES-1:0]  lane_we,
  input  logic              ce_a,
  input  logic              ce_b,
  input  logic              ce_c,
  input  logic              oe,
  input  logic              sleep,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              sel_all;
  logic              s1_v, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_lanes;
  logic              s2_v, s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_lanes;
  logic              cm_en;
  logic [ADDR_W-1:0] cm_addr;
  logic [LANES-1:0]  cm_lanes;
  logic [DATA_W-1:0] rd_data, fwd_data, rd_q, rd_word;
  logic              rd_v_q, rd_live, hit;

  assign sel_all = ce_a & ce_b & ce_c;

  zt_sram_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk(clk), .rst(rst), .sleep(sleep), .lin_burst(lin_burst),
    .adv_ld(adv_ld), .we(we), .sel_all(sel_all), .addr(addr), .lane_we(lane_we),
    .c_v(s1_v), .c_wr(s1_wr), .c_addr(s1_addr), .c_lanes(s1_lanes)
  );

  // second command stage for the double late write
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v     <= 1'b0;
      s2_wr    <= 1'b0;
      s2_addr  <= '0;
      s2_lanes <= '0;
    end else begin
      s2_v     <= s1_v;
      s2_wr    <= s1_wr;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
    end
  end

  // commit point: data on din belongs to the stage chosen by the mode
  always_comb begin
    if (flow_mode) begin
      cm_en    = s1_v & s1_wr & ~sleep;
      cm_addr  = s1_addr;
      cm_lanes = s1_lanes;
    end else begin
      cm_en    = s2_v & s2_wr & ~sleep;
      cm_addr  = s2_addr;
      cm_lanes = s2_lanes;
    end
  end

  zt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wr_en(cm_en), .wr_addr(cm_addr), .wr_lanes(cm_lanes),
    .wr_data(din), .rd_addr(s1_addr), .rd_data(rd_data)
  );

  // forward a same-edge commit into the registered read word
  assign hit = cm_en && (cm_addr == s1_addr);
  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign fwd_data[g*LANE_W +: LANE_W] = (hit && cm_lanes[g]) ?
        din[g*LANE_W +: LANE_W] : rd_data[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      rd_v_q <= s1_v & ~s1_wr;
      rd_q   <= fwd_data;
    end
  end

  assign rd_live = flow_mode ? (s1_v & ~s1_wr) : rd_v_q;
  assign rd_word = flow_mode ? rd_data : rd_q;
  assign dout_en = oe & ~sleep & rd_live;
  assign dout    = dout_en ? rd_word : '0;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              flow_mode,
  input logic              adv_ld,
  input logic              sleep,
  input logic              oe,
  input logic              sel_all,
  input logic              s1_v,
  input logic              s1_wr,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              dout_en
);
  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !dout_en);

  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dout_en);

  // R9
  sleep_block_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !s1_v);

  // R7
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !adv_ld && !sel_all) |=> !s1_v);

  // R12
  adv_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_ld && !s1_v) |=> !s1_v);

  // R10
  burst_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && adv_ld && s1_v) |=>
      (s1_v && s1_wr == $past(s1_wr) &&
       s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  // R2
  pipe_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (!flow_mode && s1_v && !s1_wr) |=> (dout_en == (oe && !sleep)));

  // R3
  flow_now_chk: assert property (@(posedge clk) disable iff (rst)
    (flow_mode && s1_v && !s1_wr && oe && !sleep) |-> dout_en);
endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .flow_mode(flow_mode), .adv_ld(adv_ld),
  .sleep(sleep), .oe(oe), .sel_all(sel_all), .s1_v(s1_v), .s1_wr(s1_wr),
  .s1_addr(s1_addr), .dout_en(dout_en)
);

// File: tb/sim_zt_sram.sv
`timescale 1ns/1ps
module sim_zt_sram;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flow_mode = 1'b0, lin_burst = 1'b1;
  logic [8:0]  addr = '0;
  logic        adv_ld = 1'b0, we = 1'b0;
  logic [1:0]  lane_we = '0;
  logic        ce_a = 1'b0, ce_b = 1'b0, ce_c = 1'b0;
  logic        oe = 1'b1, sleep = 1'b0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic        dout_en;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  zt_sram u0 (
    .clk(clk), .rst(rst), .flow_mode(flow_mode), .lin_burst(lin_burst),
    .addr(addr), .adv_ld(adv_ld), .we(we), .lane_we(lane_we),
    .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .oe(oe), .sleep(sleep),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  localparam logic [17:0] P0 = 18'h15A3C;
  localparam logic [17:0] P1 = 18'h0C3F1;
  localparam logic [17:0] MK = 18'h3E1D7;
  localparam logic [17:0] QW = 18'h2B64E;
  localparam logic [17:0] MG = {P0[17:9], MK[8:0]};

  typedef struct packed {
    logic        ce;
    logic        adv;
    logic        wr;
    logic [1:0]  ln;
    logic [8:0]  a;
    logic [17:0] d;
    logic        en;
    logic [17:0] q;
  } vec_t;

  // registered-output timing, linear order
  localparam vec_t VEC [0:10] = '{
    '{1'b1, 1'b0, 1'b1, 2'b11, 9'h012, 18'h0, 1'b0, 18'h0},
    '{1'b1, 1'b0, 1'b1, 2'b11, 9'h013, 18'h0, 1'b0, 18'h0},
    '{1'b1, 1'b0, 1'b1, 2'b01, 9'h012, P0,    1'b0, 18'h0},
    '{1'b1, 1'b0, 1'b0, 2'b11, 9'h012, P1,    1'b0, 18'h0},
    '{1'b1, 1'b0, 1'b0, 2'b11, 9'h013, MK,    1'b1, MG},
    '{1'b1, 1'b0, 1'b1, 2'b11, 9'h020, 18'h0, 1'b1, P1},
    '{1'b1, 1'b0, 1'b0, 2'b11, 9'h012, 18'h0, 1'b0, 18'h0},
    '{1'b0, 1'b0, 1'b0, 2'b11, 9'h000, QW,    1'b1, MG},
    '{1'b1, 1'b0, 1'b0, 2'b11, 9'h020, 18'h0, 1'b0, 18'h0},
    '{1'b0, 1'b0, 1'b0, 2'b11, 9'h000, 18'h0, 1'b1, QW},
    '{1'b0, 1'b0, 1'b0, 2'b11, 9'h000, 18'h0, 1'b0, 18'h0}
  };

  function automatic logic [17:0] d_of(input logic [8:0] a);
    return 18'h100 + {9'd0, a};
  endfunction

  task automatic step(input logic [2:0] ce, input logic adv, input logic wr,
                      input logic [1:0] ln, input logic [8:0] a, input logic [17:0] d);
    @(negedge clk);
    {ce_a, ce_b, ce_c} = ce;
    adv_ld = adv; we = wr; lane_we = ln; addr = a; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic en_exp, input logic [17:0] q_exp);
    checks++;
    if (dout_en !== en_exp || dout !== q_exp) begin
      fails++;
      $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h",
               tag, dout_en, dout, en_exp, q_exp);
    end
  endtask

  task automatic do_reset(input logic fm, input logic lb);
    @(negedge clk);
    rst = 1'b1; flow_mode = fm; lin_burst = lb;
    {ce_a, ce_b, ce_c} = 3'b000; adv_ld = 1'b0; we = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R1 during reset", 1'b0, 18'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // table: latency, late write, masking, forwarding, turnaround
    do_reset(1'b0, 1'b1);
    step(3'b000, 1'b0, 1'b0, 2'b00, 9'h0, 18'h0);
    check("R1 after reset release", 1'b0, 18'h0);
    for (int i = 0; i < 11; i++) begin
      step({3{VEC[i].ce}}, VEC[i].adv, VEC[i].wr, VEC[i].ln, VEC[i].a, VEC[i].d);
      check($sformatf("R2/R4/R5/R6/R11 vector %0d", i), VEC[i].en, VEC[i].q);
    end

    // R12: advance right after reset and after deselect
    do_reset(1'b0, 1'b1);
    step(3'b111, 1'b1, 1'b0, 2'b11, 9'h012, 18'h0);
    step(3'b111, 1'b1, 1'b0, 2'b11, 9'h012, 18'h0);
    check("R12 advance after reset", 1'b0, 18'h0);
    step(3'b111, 1'b1, 1'b0, 2'b11, 9'h012, 18'h0);
    check("R1 advance after reset idle", 1'b0, 18'h0);

    // R10 linear write burst from 0x041, ce/we/addr ignored on advance
    step(3'b111, 1'b0, 1'b1, 2'b11, 9'h041, 18'h0);
    step(3'b000, 1'b1, 1'b0, 2'b11, 9'h1FF, 18'h0);
    step(3'b000, 1'b1, 1'b0, 2'b11, 9'h1FF, d_of(9'h041));
    step(3'b000, 1'b1, 1'b0, 2'b11, 9'h1FF, d_of(9'h042));
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h0,   d_of(9'h043));
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h0,   d_of(9'h040));
    // R10 interleaved read burst from 0x041: 041,040,043,042
    do_reset(1'b0, 1'b0);
    step(3'b111, 1'b0, 1'b0, 2'b11, 9'h041, 18'h0);
    check("R2 first cycle of read burst", 1'b0, 18'h0);
    step(3'b000, 1'b1, 1'b1, 2'b11, 9'h000, 18'h0);
    check("R10 interleaved beat 0", 1'b1, d_of(9'h041));
    step(3'b000, 1'b1, 1'b1, 2'b11, 9'h000, 18'h0);
    check("R10 interleaved beat 1", 1'b1, d_of(9'h040));
    step(3'b000, 1'b1, 1'b1, 2'b11, 9'h000, 18'h0);
    check("R10 interleaved beat 2", 1'b1, d_of(9'h043));
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h000, 18'h0);
    check("R10 interleaved beat 3", 1'b1, d_of(9'h042));
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h000, 18'h0);
    check("R7 burst ends on deselect", 1'b0, 18'h0);

    // R9 sleep blocks a write, contents kept
    do_reset(1'b0, 1'b1);
    step(3'b111, 1'b0, 1'b1, 2'b11, 9'h050, 18'h0);
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h000, 18'h0);
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h000, 18'h0A0A1);
    sleep = 1'b1;
    step(3'b111, 1'b0, 1'b1, 2'b11, 9'h050, 18'h0);
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h000, 18'h0);
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h000, 18'h3FFFF);
    sleep = 1'b0;
    step(3'b111, 1'b0, 1'b0, 2'b11, 9'h050, 18'h0);
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h000, 18'h0);
    check("R9 write during sleep ignored", 1'b1, 18'h0A0A1);
    // R7 write with one chip enable low is ignored
    step(3'b101, 1'b0, 1'b1, 2'b11, 9'h050, 18'h0);
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h000, 18'h0);
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h000, 18'h15555);
    step(3'b111, 1'b0, 1'b0, 2'b11, 9'h050, 18'h0);
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h000, 18'h0);
    check("R7 deselected write ignored", 1'b1, 18'h0A0A1);
    step(3'b011, 1'b0, 1'b0, 2'b11, 9'h050, 18'h0);
    step(3'b000, 1'b0, 1'b0, 2'b11, 9'h000, 18'h0);
    check("R7 deselected read drives nothing", 1'b0, 18'h0);

    // flow-through timing
    do_reset(1'b1, 1'b1);
    step(3'b111, 1'b0, 1'b1, 2'b11, 9'h030, 18'h0);
    check("R3 write cycle drives nothing", 1'b0, 18'h0);
    step(3'b111, 1'b0, 1'b0, 2'b11, 9'h030, 18'h1B2C3);
    check("R3/R4/R5 read right after write", 1'b1, 18'h1B2C3);
    step(3'b111, 1'b0, 1'b1, 2'b10, 9'h030, 18'h0);
    check("R5 write after read", 1'b0, 18'h0);
    step(3'b111, 1'b0, 1'b0, 2'b11, 9'h030, 18'h2D4E5);
    check("R6 upper lane only", 1'b1, {9'h16A, 9'h0C3});
    oe = 1'b0; #1;
    check("R8 output enable low", 1'b0, 18'h0);
    oe = 1'b1; #1;
    check("R8 output enable restored", 1'b1, {9'h16A, 9'h0C3});
    sleep = 1'b1; #1;
    check("R9 sleep gates output", 1'b0, 18'h0);
    sleep = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule